// File: doc/BRIEF.md
# Four-State Viterbi Add-Compare-Select Unit

This block performs the add-compare-select recursion for a rate-1/2 convolutional code whose encoder keeps two bits of history, so the trellis has four states. Each time `in_valid` is high, the block takes four branch metrics and extends the four path metrics it holds. There is one branch metric for each possible pair of encoder output bits. For every state it keeps the better of the two incoming paths and emits one survivor bit. Each step therefore yields a 4-bit decision vector, which a traceback stage further down the chain consumes.

Path metrics are never renormalized. The accumulators wrap freely modulo 2^W, where W is the soft-decision width plus three. Survivors are chosen with a comparison that still gives the right answer across the wrap: an unsigned compare of every bit below the MSB, XORed with a flag that is set when the two MSBs differ. A larger metric means a better path. The soft-decision width is a parameter with a default of 3, which gives 6-bit path metrics.

Top module: `viterbi_acs4`

## Requirements
- R1: While `rst` is high and on the first cycle after it is released, `out_valid` is 0 and `dec_out` is 0. State 0 holds metric 0, and states 1 to 3 hold 2^W - 2^(W-2), which is 48 for W = 6.
- R2: The branch metric for output pair {X,Y} sits at `bm_in[(2X+Y)*SD_W +: SD_W]`. On the transition from state s with input bit u, the encoder emits X = u (generator mask 100 over {u,s[1],s[0]}) and Y = s[0] (generator mask 001).
- R3: The next state is {u, s[1]}. Each candidate metric is the predecessor's metric plus its branch metric, taken modulo 2^W. The stored metric of state n, at `sm_out[n*W +: W]`, is one of its two candidates.
- R4: "a beats b" is defined as (a[W-2:0] > b[W-2:0] unsigned) XOR (a[W-1] != b[W-1]). Bit n of `dec_out` is 1 when the candidate from predecessor {n[0],1} beats the one from {n[0],0}, and the stored metric is that winner.
- R5: When the two candidates of a state are equal, the predecessor with LSB 0 is kept and its decision bit is 0.
- R6: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` was high. The updated metrics and the decision vector appear in that same cycle, including on back-to-back steps.
- R7: While `in_valid` is low, `out_valid` is 0, and `sm_out` and `dec_out` keep their values whatever `bm_in` carries.
- R8: Over long runs of branch metrics in the range 0 to 2^SD_W - 1, the survivors match those picked from full-width metrics that never wrap, and `sm_out` equals those metrics modulo 2^W. The wrapped metrics of any two states stay within 3*2^SD_W of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Branch metrics valid; one trellis step is taken |
| bm_in | input | 4*SD_W | Four branch metrics, slot index {X,Y} |
| out_valid | output | 1 | Step result valid, one cycle after in_valid |
| sm_out | output | 4*(SD_W+3) | Path metrics of states 0 to 3, state n in slot n |
| dec_out | output | 4 | Survivor bit per state (predecessor LSB) |

## Verification
The hardest situation to reach from the ports is a comparison in which the two candidates lie on opposite sides of the wrap point. That only happens once the accumulators have gone around the modulo range many times. The stimulus gets there with thousands of back-to-back steps of random branch metrics, checked against a 64-bit reference that never wraps. A final check confirms that the reference metrics grew far beyond 2^W. Exact ties and the branch-metric routing come from short directed sequences started right after reset, where every expected metric is known in closed form.

// File: rtl/acs4_pkg.sv
package acs4_pkg;
  localparam int MEM = 2;
  localparam int NST = 1 << MEM;

  localparam logic [MEM:0] GEN_X = 3'b100;
  localparam logic [MEM:0] GEN_Y = 3'b001;

  // parity of the masked {input, state} word
  function automatic logic enc_bit(logic [MEM:0] gen, logic u, logic [MEM-1:0] s);
    return ^({u, s} & gen);
  endfunction

  // the two states leading to ns differ only in their LSB
  function automatic logic [MEM-1:0] pred_of(logic [MEM-1:0] ns, logic b);
    return {ns[MEM-2:0], b};
  endfunction

  // branch metric slot {X,Y} for the transition pred_of(ns,b) -> ns
  function automatic logic [1:0] symbol_of(logic [MEM-1:0] ns, logic b);
    logic [MEM-1:0] p;
    logic u;
    p = pred_of(ns, b);
    u = ns[MEM-1];
    return {enc_bit(GEN_X, u, p), enc_bit(GEN_Y, u, p)};
  endfunction

  // start-up metric: state 0 leads by a quarter of the modulo range
  function automatic int init_metric(int idx, int w);
    return (idx == 0) ? 0 : ((1 << w) - (1 << (w - 2)));
  endfunction
endpackage

// File: rtl/acs_node.sv
module acs_node #(
  parameter int SD_W = 3,
  parameter int SM_W = SD_W + 3
) (
  input  logic [SM_W-1:0] pm_lo,
  input  logic [SM_W-1:0] pm_hi,
  input  logic [SD_W-1:0] bm_lo,
  input  logic [SD_W-1:0] bm_hi,
  output logic [SM_W-1:0] cand_lo,
  output logic [SM_W-1:0] cand_hi,
  output logic [SM_W-1:0] survivor,
  output logic            pick_hi
);
  localparam int LOW_W = SM_W - 1;

  function automatic logic [SM_W-1:0] wrap_add(logic [SM_W-1:0] m, logic [SD_W-1:0] b);
    return m + SM_W'(b);
  endfunction

  // modulo-aware "a beats b"
  function automatic logic beats(logic [SM_W-1:0] a, logic [SM_W-1:0] b);
    logic low_gt;
    logic msb_mis;
    low_gt  = a[LOW_W-1:0] > b[LOW_W-1:0];
    msb_mis = a[SM_W-1] ^ b[SM_W-1];
    return low_gt ^ msb_mis;
  endfunction

  always_comb begin
    cand_lo  = wrap_add(pm_lo, bm_lo);
    cand_hi  = wrap_add(pm_hi, bm_hi);
    pick_hi  = beats(cand_hi, cand_lo);
    survivor = pick_hi ? cand_hi : cand_lo;
  end
endmodule

// File: rtl/acs_metric_bank.sv
module acs_metric_bank
  import acs4_pkg::*;
#(
  parameter int SM_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [NST*SM_W-1:0] nxt,
  output logic [NST*SM_W-1:0] cur
);
  for (genvar s = 0; s < NST; s++) begin : g_reg
    localparam logic [SM_W-1:0] RST_V = SM_W'(init_metric(s, SM_W));
    logic [SM_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)       q <= RST_V;
      else if (load) q <= nxt[s*SM_W +: SM_W];
    end
    assign cur[s*SM_W +: SM_W] = q;
  end
endmodule

// File: rtl/viterbi_acs4.sv
module viterbi_acs4
  import acs4_pkg::*;
#(
  parameter int SD_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [4*SD_W-1:0]      bm_in,
  output logic                   out_valid,
  output logic [4*(SD_W+3)-1:0]  sm_out,
  output logic [3:0]             dec_out
);
  localparam int SM_W = SD_W + 3;

  // named internal events, observed by the bound checker
  logic [NST*SM_W-1:0] cand_lo_all;
  logic [NST*SM_W-1:0] cand_hi_all;
  logic [NST*SM_W-1:0] surv_all;
  logic [NST-1:0]      pick_vec;

  for (genvar n = 0; n < NST; n++) begin : g_state
    localparam logic [MEM-1:0] NS   = MEM'(n);
    localparam int             P_LO = int'(pred_of(NS, 1'b0));
    localparam int             P_HI = int'(pred_of(NS, 1'b1));
    localparam int             S_LO = int'(symbol_of(NS, 1'b0));
    localparam int             S_HI = int'(symbol_of(NS, 1'b1));

    acs_node #(.SD_W(SD_W), .SM_W(SM_W)) u_node (
      .pm_lo   (sm_out[P_LO*SM_W +: SM_W]),
      .pm_hi   (sm_out[P_HI*SM_W +: SM_W]),
      .bm_lo   (bm_in[S_LO*SD_W +: SD_W]),
      .bm_hi   (bm_in[S_HI*SD_W +: SD_W]),
      .cand_lo (cand_lo_all[n*SM_W +: SM_W]),
      .cand_hi (cand_hi_all[n*SM_W +: SM_W]),
      .survivor(surv_all[n*SM_W +: SM_W]),
      .pick_hi (pick_vec[n])
    );
  end

  acs_metric_bank #(.SM_W(SM_W)) u_bank (
    .clk (clk),
    .rst (rst),
    .load(in_valid),
    .nxt (surv_all),
    .cur (sm_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dec_out   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) dec_out <= pick_vec;
    end
  end
endmodule

// File: rtl/acs4_chk.sv
module acs4_chk #(
  parameter int SD_W = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic                  out_valid,
  input logic [4*(SD_W+3)-1:0] sm_out,
  input logic [3:0]            dec_out,
  input logic [4*(SD_W+3)-1:0] cand_lo_all,
  input logic [4*(SD_W+3)-1:0] cand_hi_all
);
  localparam int SM_W = SD_W + 3;
  localparam logic [SM_W-1:0] SPREAD_LIM = SM_W'(3 << SD_W);

  logic spread_ok;
  always_comb begin
    spread_ok = 1'b1;
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        logic [SM_W-1:0] d;
        logic [SM_W-1:0] mag;
        d   = sm_out[i*SM_W +: SM_W] - sm_out[j*SM_W +: SM_W];
        mag = d[SM_W-1] ? (~d + 1'b1) : d;
        if (mag >= SPREAD_LIM) spread_ok = 1'b0;
      end
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) $past(rst) |-> (!out_valid && dec_out == 4'b0));

  // R6
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);

  // R6
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);

  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(sm_out) && $stable(dec_out)));

  // R8
  spread_bound_chk: assert property (@(posedge clk) disable iff (rst) spread_ok);

  for (genvar n = 0; n < 4; n++) begin : g_st
    // R3
    metric_from_cand_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (sm_out[n*SM_W +: SM_W] == $past(cand_lo_all[n*SM_W +: SM_W]) ||
                    sm_out[n*SM_W +: SM_W] == $past(cand_hi_all[n*SM_W +: SM_W])));

    // R4
    dec_matches_metric_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (sm_out[n*SM_W +: SM_W] ==
                    (dec_out[n] ? $past(cand_hi_all[n*SM_W +: SM_W])
                                : $past(cand_lo_all[n*SM_W +: SM_W]))));

    // R5
    tie_low_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && cand_lo_all[n*SM_W +: SM_W] == cand_hi_all[n*SM_W +: SM_W]) |=> !dec_out[n]);
  end
endmodule

bind viterbi_acs4 acs4_chk #(.SD_W(SD_W)) u_acs4_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .sm_out     (sm_out),
  .dec_out    (dec_out),
  .cand_lo_all(cand_lo_all),
  .cand_hi_all(cand_hi_all)
);

// File: tb/test_viterbi_acs4.sv
module test_viterbi_acs4;
  localparam int SD_W = 3;
  localparam int SM_W = SD_W + 3;
  localparam int NST  = 4;

  logic                 clk = 1'b0;
  logic                 rst;
  logic                 in_valid;
  logic [NST*SD_W-1:0]  bm_in;
  logic                 out_valid;
  logic [NST*SM_W-1:0]  sm_out;
  logic [NST-1:0]       dec_out;

  int        n_chk = 0;
  int        n_bad = 0;
  bit        done  = 1'b0;
  longint    ref_m [NST];
  logic [NST-1:0] ref_dec;
  longint    ref_peak = 0;

  always #2 clk = ~clk;

  viterbi_acs4 #(.SD_W(SD_W)) i_viterbi_acs4 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .bm_in(bm_in),
    .out_valid(out_valid), .sm_out(sm_out), .dec_out(dec_out)
  );

  function automatic longint wrap(longint v);
    return v & ((64'sd1 <<< SM_W) - 1);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    for (int s = 0; s < NST; s++)
      check(longint'(sm_out[s*SM_W +: SM_W]) == wrap(ref_m[s]), req, $sformatf("metric[%0d]", s),
            longint'(sm_out[s*SM_W +: SM_W]), wrap(ref_m[s]));
    check(dec_out == ref_dec, req, "decisions", longint'(dec_out), longint'(ref_dec));
  endtask

  // one trellis step; caller sits at a falling edge
  task automatic step(int b0, int b1, int b2, int b3, string req);
    int     bm [NST];
    longint nx [NST];
    bm = '{b0, b1, b2, b3};
    in_valid = 1'b1;
    for (int i = 0; i < NST; i++) bm_in[i*SD_W +: SD_W] = SD_W'(bm[i]);
    for (int n = 0; n < NST; n++) begin
      int     u  = n >> 1;
      int     p0 = (n & 1) * 2;
      longint c0 = ref_m[p0] + bm[u*2];
      longint c1 = ref_m[p0+1] + bm[u*2+1];
      ref_dec[n] = (c1 > c0);
      nx[n]      = (c1 > c0) ? c1 : c0;
      if (nx[n] > ref_peak) ref_peak = nx[n];
    end
    ref_m = nx;
    @(negedge clk);
    check(out_valid == 1'b1, "R6", "out_valid after step", longint'(out_valid), 1);
    check_all(req);
  endtask

  task automatic idle(int cycles);
    in_valid = 1'b0;
    for (int c = 0; c < cycles; c++) begin
      bm_in = NST*SD_W'($urandom);
      @(negedge clk);
      check(out_valid == 1'b0, "R7", "out_valid idle", longint'(out_valid), 0);
      check_all("R7");
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; bm_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    ref_m   = '{0, -16, -16, -16};
    ref_dec = '0;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    check(out_valid == 1'b0, "R1", "out_valid", longint'(out_valid), 0);
    check(dec_out == 4'b0, "R1", "dec_out", longint'(dec_out), 0);
    check(sm_out[0 +: SM_W] == 6'd0, "R1", "metric0", longint'(sm_out[0 +: SM_W]), 0);
    for (int s = 1; s < NST; s++)
      check(sm_out[s*SM_W +: SM_W] == 6'd48, "R1", $sformatf("metric%0d", s),
            longint'(sm_out[s*SM_W +: SM_W]), 48);
  endtask

  // only slot {X=1,Y=0} carries weight: lands on state 2 from state 0
  task automatic t_routing();
    do_reset();
    step(0, 0, 7, 0, "R2");
    check(sm_out[2*SM_W +: SM_W] == 6'd7,  "R2", "state2 metric", longint'(sm_out[2*SM_W +: SM_W]), 7);
    check(sm_out[3*SM_W +: SM_W] == 6'd55, "R2", "state3 metric", longint'(sm_out[3*SM_W +: SM_W]), 55);
    check(sm_out[1*SM_W +: SM_W] == 6'd48, "R3", "state1 metric", longint'(sm_out[1*SM_W +: SM_W]), 48);
    step(5, 1, 2, 7, "R3");
    step(0, 7, 3, 3, "R4");
  endtask

  // all-zero metrics right after reset: states 1 and 3 see equal candidates
  task automatic t_tie();
    do_reset();
    step(0, 0, 0, 0, "R5");
    check(dec_out[1] == 1'b0, "R5", "tie state1", longint'(dec_out[1]), 0);
    check(dec_out[3] == 1'b0, "R5", "tie state3", longint'(dec_out[3]), 0);
  endtask

  task automatic t_hold();
    step(3, 6, 1, 4, "R6");
    step(7, 2, 5, 0, "R6");
    idle(5);
  endtask

  task automatic t_long_random();
    do_reset();
    for (int k = 0; k < 3000; k++) begin
      step($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
           $urandom_range(0, 7), "R4 R8");
      if ($urandom_range(0, 15) == 0) idle(1);
    end
    check(ref_peak > 64'd1000, "R8", "wrap depth reached", ref_peak, 1000);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; bm_in = '0;
    t_reset_state();
    t_routing();
    t_tie();
    t_hold();
    t_long_random();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule